// File: doc/BRIEF.md
# Launch Countdown Sequencer

This block runs a one-digit launch countdown. After power-up it shows 0 on a seven-segment display, holds its lamp output on and waits. A press of the start pushbutton turns the lamp off, loads 9 and counts down by one each second. When the display reaches 0, the count stops there and the lamp comes back on. It stays on until the next press.

The raw button is synchronised and debounced over a window of about 50 ms. Only a clean rising edge of the debounced level counts as a press. A press made while the count is running has no effect. The one-second step comes from a prescaler derived from the clock frequency parameter, so the period can be trimmed. The prescaler is gated off while zero is shown, which is what freezes the count. Zero itself is recognised from the segment pattern rather than from the binary count. The asynchronous reset input is synchronised, and the core is then held in reset for about another 50 ms.

Top module: `launch_countdown`

## Requirements
- R1: After reset the display shows the zero pattern 7'h3F, lamp is 1 and running is 0. Segments a..g sit on bits 0..6 and are active high.
- R2: Button pulses shorter than the debounce window (CLK_HZ/20 cycles) never start a countdown.
- R3: A debounced press while zero is shown loads 9 (pattern 7'h6F), clears lamp and raises running.
- R4: Each tick lowers the digit by exactly one. The display walks through 7'h6F, 7'h7F, 7'h07, 7'h7D, 7'h6D, 7'h66, 7'h4F, 7'h5B, 7'h06, 7'h3F.
- R5: The first step after 9 appears comes no later than one period (CLK_HZ cycles). Every later step comes exactly CLK_HZ cycles after the previous one.
- R6: While zero is shown and no press arrives, the tick is suppressed and the display never changes or wraps to 9.
- R7: Lamp is 1 in exactly the cycles in which the zero pattern is shown. This covers power-up, and it falls only with the press that reloads 9.
- R8: A press whose debounced rising edge falls while a digit other than zero is shown is ignored. A button still held when zero arrives does not restart the count.
- R9: Running is 1 from the reload to 9 until the cycle in which zero is shown, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| start_btn | input | 1 | Raw start pushbutton, active high, may bounce |
| seg | output | 7 | Segment lines a..g on bits 0..6, active high |
| lamp | output | 1 | Lamp relay enable |
| running | output | 1 | High while a countdown is in progress |

## Verification
The tick that takes the digit from 1 to 0 and a start press can meet in the same cycle. The block must resolve that meeting so that the press is lost and the count stays frozen. The bench raises the button while 1 is on the display and keeps it held across the step to zero and well beyond. It then judges through the ports that the display stays at the zero pattern, the lamp stays on and no further step appears. A later clean press must still restart the sequence.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef logic [3:0] digit_t;
  typedef logic [6:0] seg_t;

  localparam digit_t TOP_DIGIT = 4'd9;
  localparam seg_t   SEG_ZERO  = 7'h3F;

  // bit 0 = a ... bit 6 = g, active high
  function automatic seg_t digit_to_seg(input digit_t d);
    seg_t s;
    case (d)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/lc_rst_hold.sv
module lc_rst_hold #(
  parameter int HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic core_rst_n
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic          sync1, sync2;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
    end else begin
      sync1 <= 1'b1;
      sync2 <= sync1;
    end
  end

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (sync2 && !done_q) begin
      if (cnt_q == LAST) done_d = 1'b1;
      else               cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign core_rst_n = done_q;
endmodule

// File: rtl/lc_debounce.sv
module lc_debounce #(
  parameter int WIN_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic level,
  output logic rise
);
  localparam int CW = $clog2(WIN_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

  logic          sync1, sync2;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          stable_q, stable_d;
  logic          rise_q, rise_d;

  always_comb begin
    cnt_d    = '0;
    stable_d = stable_q;
    rise_d   = 1'b0;
    if (sync2 != stable_q) begin
      if (cnt_q == LAST) begin
        stable_d = sync2;
        rise_d   = sync2;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1    <= 1'b0;
      sync2    <= 1'b0;
      cnt_q    <= '0;
      stable_q <= 1'b0;
      rise_q   <= 1'b0;
    end else begin
      sync1    <= raw_in;
      sync2    <= sync1;
      cnt_q    <= cnt_d;
      stable_q <= stable_d;
      rise_q   <= rise_d;
    end
  end

  assign level = stable_q;
  assign rise  = rise_q;
endmodule

// File: rtl/lc_prescale.sv
module lc_prescale #(
  parameter int PERIOD = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = $clog2(PERIOD + 1);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!en)                cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = en && (cnt_q == LAST);
endmodule

// File: rtl/launch_countdown.sv
module launch_countdown
  import lc_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_btn,
  output logic [6:0] seg,
  output logic       lamp,
  output logic       running
);
  localparam int TICK_CYCLES = CLK_HZ;
  localparam int DEB_CYCLES  = (CLK_HZ / 20 > 0) ? CLK_HZ / 20 : 1;
  localparam int HOLD_CYCLES = (CLK_HZ / 20 > 0) ? CLK_HZ / 20 : 1;

  logic   core_rst_n;
  logic   btn_level, start_rise;
  logic   tick, zero_shown;
  digit_t digit, digit_d;
  logic   lamp_q, lamp_d;
  seg_t   seg_w;

  lc_rst_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .core_rst_n(core_rst_n));

  lc_debounce #(.WIN_CYCLES(DEB_CYCLES)) u_deb (
    .clk(clk), .rst_n(core_rst_n), .raw_in(start_btn),
    .level(btn_level), .rise(start_rise));

  lc_prescale #(.PERIOD(TICK_CYCLES)) u_tick (
    .clk(clk), .rst_n(core_rst_n), .en(!zero_shown), .tick(tick));

  // zero is the only digit with g dark and f lit
  assign seg_w      = digit_to_seg(digit);
  assign zero_shown = !seg_w[6] && seg_w[5];

  always_comb begin
    digit_d = digit;
    lamp_d  = lamp_q;
    if (start_rise && zero_shown) begin
      digit_d = TOP_DIGIT;
      lamp_d  = 1'b0;
    end else if (tick) begin
      digit_d = digit - 1'b1;
      if (digit == 4'd1) lamp_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      digit  <= '0;
      lamp_q <= 1'b1;
    end else begin
      digit  <= digit_d;
      lamp_q <= lamp_d;
    end
  end

  assign seg     = seg_w;
  assign lamp    = lamp_q;
  assign running = !zero_shown;

  logic unused_level;
  assign unused_level = btn_level;
endmodule

// File: rtl/lc_checker.sv
module lc_checker (
  input logic       clk,
  input logic       core_rst_n,
  input logic [3:0] digit,
  input logic       tick,
  input logic       start_rise,
  input logic [6:0] seg,
  input logic       lamp,
  input logic       running
);
  assert_lamp_zero_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
    lamp == (seg == 7'h3F));

  assert_running_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    running != lamp);

  assert_freeze_R6: assert property (@(posedge clk) disable iff (!core_rst_n)
    (seg == 7'h3F && !start_rise) |=> (seg == 7'h3F));

  assert_tick_gated_R6: assert property (@(posedge clk) disable iff (!core_rst_n)
    tick |-> (digit != 4'd0));

  assert_step_R4: assert property (@(posedge clk) disable iff (!core_rst_n)
    tick |=> (digit == $past(digit) - 4'd1));

  assert_reload_R3: assert property (@(posedge clk) disable iff (!core_rst_n)
    (start_rise && seg == 7'h3F) |=> (digit == 4'd9 && !lamp && running));

  assert_ignore_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
    (start_rise && digit != 4'd0 && !tick) |=> $stable(digit));
endmodule

bind launch_countdown lc_checker i_lc_checker (
  .clk(clk), .core_rst_n(core_rst_n), .digit(digit), .tick(tick),
  .start_rise(start_rise), .seg(seg), .lamp(lamp), .running(running));

// File: tb/test_launch_countdown.sv
module test_launch_countdown;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 200;
  localparam int TICK       = CLK_HZ;
  localparam int DEB        = CLK_HZ / 20;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_btn;
  logic [6:0] seg;
  logic       lamp, running;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mon_en = 1'b0;
  logic [6:0] prev_seg;
  logic [6:0] exp_q[$];
  int change_idx;
  int last_change;
  int press_cyc;

  always #(CLK_PERIOD/2) clk = ~clk;

  launch_countdown #(.CLK_HZ(CLK_HZ)) i_launch_countdown (
    .clk(clk), .rst_n(rst_n), .start_btn(start_btn),
    .seg(seg), .lamp(lamp), .running(running));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // driver: clean press, queue the expected display walk
  task automatic press_start();
    for (int d = 9; d >= 0; d--) begin
      case (d)
        9: exp_q.push_back(7'h6F); 8: exp_q.push_back(7'h7F);
        7: exp_q.push_back(7'h07); 6: exp_q.push_back(7'h7D);
        5: exp_q.push_back(7'h6D); 4: exp_q.push_back(7'h66);
        3: exp_q.push_back(7'h4F); 2: exp_q.push_back(7'h5B);
        1: exp_q.push_back(7'h06); default: exp_q.push_back(7'h3F);
      endcase
    end
    change_idx = 0;
    press_cyc  = cyc;
    start_btn  = 1'b1;
    wait_cyc(3 * DEB);
    start_btn  = 1'b0;
  endtask

  task automatic wait_empty();
    int n = 0;
    while (exp_q.size() != 0 && n < 20 * TICK) begin
      @(negedge clk);
      n++;
    end
    check(exp_q.size() == 0, "R4 sequence completes", exp_q.size(), 0);
  endtask

  // monitor: pop and compare on every display change
  always @(negedge clk) begin
    cyc++;
    if (mon_en && seg !== prev_seg) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected display change", int'(seg), int'(prev_seg));
      end else begin
        logic [6:0] e;
        e = exp_q.pop_front();
        check(seg === e, "R4 display pattern", int'(seg), int'(e));
        if (e == 7'h3F)
          check(lamp === 1'b1 && running === 1'b0, "R7 lamp on at zero R9", {lamp, running}, 2);
        else
          check(lamp === 1'b0 && running === 1'b1, "R9 running during count", {lamp, running}, 1);
        if (change_idx == 0)
          check(cyc - press_cyc <= 3 * DEB + 4, "R3 reload latency", cyc - press_cyc, 3 * DEB + 4);
        else if (change_idx == 1)
          check(cyc - last_change <= TICK && cyc - last_change > 0, "R5 first step", cyc - last_change, TICK);
        else
          check(cyc - last_change == TICK, "R5 step spacing", cyc - last_change, TICK);
        change_idx++;
        last_change = cyc;
      end
    end
    prev_seg = seg;
  end

  initial begin
    wait_cyc(WATCHDOG);
    check(1'b0, "watchdog expired", cyc, WATCHDOG);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start_btn = 1'b0;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(DEB + 10);
    check(seg === 7'h3F, "R1 reset display", int'(seg), 'h3F);
    check(lamp === 1'b1, "R1 reset lamp", lamp, 1);
    check(running === 1'b0, "R1 reset running", running, 0);
    mon_en = 1'b1;

    // R2: bouncing shorter than the window
    for (int k = 0; k < 6; k++) begin
      start_btn = 1'b1; wait_cyc(DEB / 2);
      start_btn = 1'b0; wait_cyc(DEB / 2);
    end
    wait_cyc(5 * DEB);
    check(seg === 7'h3F && lamp === 1'b1, "R2 glitches ignored", int'(seg), 'h3F);

    // run 1, with a second press mid-count (R8)
    press_start();
    wait_cyc(DEB);
    check(seg === 7'h6F, "R3 loaded nine", int'(seg), 'h6F);
    check(lamp === 1'b0 && running === 1'b1, "R3 lamp off running on", {lamp, running}, 1);
    wait_cyc(3 * TICK);
    start_btn = 1'b1; wait_cyc(3 * DEB); start_btn = 1'b0;
    wait_empty();
    check(lamp === 1'b1 && running === 1'b0, "R7 lamp latched at zero", {lamp, running}, 2);

    // R6: frozen at zero
    wait_cyc(3 * TICK);
    check(seg === 7'h3F && lamp === 1'b1, "R6 held at zero", int'(seg), 'h3F);

    // run 2: button raised while 1 shown, held across zero (R8)
    press_start();
    while (exp_q.size() > 1) @(negedge clk);
    start_btn = 1'b1;
    wait_cyc(3 * TICK);
    start_btn = 1'b0;
    wait_cyc(2 * TICK);
    check(exp_q.size() == 0, "R8 zero reached despite press", exp_q.size(), 0);
    check(seg === 7'h3F && lamp === 1'b1 && running === 1'b0,
          "R8 held press does not restart", int'(seg), 'h3F);

    // run 3: next press clears the lamp (R7)
    press_start();
    wait_cyc(DEB);
    check(lamp === 1'b0, "R7 lamp cleared by press", lamp, 0);
    wait_empty();
    wait_cyc(TICK);
    check(seg === 7'h3F && lamp === 1'b1, "R6 final freeze", int'(seg), 'h3F);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule